// File: doc/BRIEF.md
# Serial Management Target for a PHY

This block is the PHY end of the two-wire serial management bus defined in Clause 22 of IEEE 802.3. It runs on the management clock and watches the data line on each rising edge. It first waits for a run of ones. It then reads a start pattern, an operation code, a five-bit PHY address and a five-bit register address. After these fields it either shifts a sixteen-bit register value out onto the line or collects sixteen bits from the station manager and commits them.

On the internal side the block connects to a small register file through a plain port. The port carries a register address, a read strobe with read data, and a write strobe with write data. The register file returns a flag that tells the block whether the addressed register exists. The block drives the shared line only through an output and an output-enable pair. The pad itself sits outside the block.

Three relaxations apply to this target. A single one bit is accepted as the preamble. An all-zero PHY address is treated as a broadcast that this target answers. A read of a register that does not exist returns sixteen ones.

Top module: `mdio_mgmt_target`

## Requirements
- R1: A frame is recognised after a preamble of any length from one to thirty-two or more consecutive ones. Zeros seen while idle are skipped.
- R2: After the preamble, the fields arrive in this order, each sampled on a rising clock edge, most significant bit first: start pattern 0 then 1, a two-bit opcode (10 = read, 01 = write), the PHY address (5 bits) and the register address (5 bits).
- R3: An opcode of 00 or 11, or a start pattern whose second bit is 0, abandons the frame with no strobe and no drive. The target then hunts for a preamble again, and a later valid frame is served normally.
- R4: On an answered read, `reg_rd_stb` is high and `mdio_oe` is low during the first turnaround bit time. During the second turnaround bit time, `mdio_oe` is high and `mdio_o` is 0.
- R5: The 16 read bits follow the turnaround, most significant bit first, one per clock. `mdio_oe` is high for exactly 17 bit times (the turnaround zero plus the data) and is low in the bit time after the last data bit.
- R6: A frame is answered when its PHY address equals the parameter `PHY_ADDR` (default 1) or is all zeros (broadcast).
- R7: For any other PHY address the target never drives the line and raises no strobe. A station manager with a pull-up therefore reads 16 ones, and a write is dropped.
- R8: An answered read of a register whose `reg_valid` is low drives sixteen ones.
- R9: An answered write raises `reg_wr_stb` for one clock, starting on the edge that samples the sixteenth data bit. `reg_wdata` holds the received word and `reg_addr` holds the register address during that clock.
- R10: A write to a register whose `reg_valid` is low raises no `reg_wr_stb`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mdc | input | 1 | Management clock; all sampling on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mdio_i | input | 1 | Data line as seen from the pad |
| mdio_o | output | 1 | Data driven toward the pad (meaningful while `mdio_oe` is high) |
| mdio_oe | output | 1 | Pad output enable |
| reg_addr | output | ADDR_W | Register address of the current frame |
| reg_rd_stb | output | 1 | Read strobe to the register file, one clock |
| reg_rdata | input | DATA_W | Read data for `reg_addr`, combinational from the file |
| reg_valid | input | 1 | High when `reg_addr` names an existing register |
| reg_wr_stb | output | 1 | Write strobe to the register file, one clock |
| reg_wdata | output | DATA_W | Write data, valid with `reg_wr_stb` |

## Verification
The properties assume that the register file answers `reg_valid` and `reg_rdata` combinationally from `reg_addr` within the same bit time. They also assume that the station manager releases the line through both turnaround bits of a read and keeps every frame whole, so that the target never sees a new frame begin while it drives. The stimulus changes `mdio_i` only on falling clock edges and holds it at 1 whenever the target may drive. It separates frames with idle bits, and it places zero runs before a frame only where a one-bit preamble is under test. Aborted frames are followed by a stretch of zeros, so that stray header bits cannot be read as a new preamble.

// File: rtl/mdio_tgt_pkg.sv
package mdio_tgt_pkg;
  // Frame walk of the target, one state per field.
  typedef enum logic [3:0] {
    ST_HUNT,   // waiting for the first preamble one
    ST_PRE,    // inside the run of ones
    ST_SOF,    // second start bit expected (must be 1)
    ST_OP,     // two opcode bits
    ST_PHY,    // PHY address field
    ST_REG,    // register address field
    ST_TA1,    // first turnaround bit
    ST_TA2,    // second turnaround bit
    ST_DATA    // sixteen data bits
  } fsm_t;

  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;
endpackage

// File: rtl/mdio_tgt_rst_sync.sv
module mdio_tgt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = pipe_q[STAGES-1];
endmodule

// File: rtl/mdio_tgt_ctrl.sv
module mdio_tgt_ctrl
  import mdio_tgt_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned CNT_W = $clog2(DATA_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_i,
  output fsm_t             state_o,
  output logic             is_read_o,
  output logic             phy_last_o,
  output logic             reg_last_o,
  output logic             data_last_o
);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

  fsm_t             state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             op_hi_q, op_hi_d;
  logic             rd_q, rd_d;

  assign phy_last_o  = (state_q == ST_PHY)  && (cnt_q == ADDR_LAST);
  assign reg_last_o  = (state_q == ST_REG)  && (cnt_q == ADDR_LAST);
  assign data_last_o = (state_q == ST_DATA) && (cnt_q == DATA_LAST);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    op_hi_d = op_hi_q;
    rd_d    = rd_q;
    case (state_q)
      ST_HUNT: if (bit_i) state_d = ST_PRE;
      ST_PRE:  if (!bit_i) state_d = ST_SOF;
      ST_SOF: begin
        cnt_d   = '0;
        state_d = bit_i ? ST_OP : ST_HUNT;
      end
      ST_OP: begin
        if (cnt_q == '0) begin
          op_hi_d = bit_i;
          cnt_d   = CNT_W'(1);
        end else begin
          cnt_d = '0;
          if ({op_hi_q, bit_i} == OP_RD) begin
            rd_d    = 1'b1;
            state_d = ST_PHY;
          end else if ({op_hi_q, bit_i} == OP_WR) begin
            rd_d    = 1'b0;
            state_d = ST_PHY;
          end else begin
            state_d = ST_HUNT;
          end
        end
      end
      ST_PHY: begin
        if (phy_last_o) begin
          cnt_d   = '0;
          state_d = ST_REG;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_REG: begin
        if (reg_last_o) begin
          cnt_d   = '0;
          state_d = ST_TA1;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_TA1: state_d = ST_TA2;
      ST_TA2: begin
        cnt_d   = '0;
        state_d = ST_DATA;
      end
      ST_DATA: begin
        if (data_last_o) begin
          cnt_d   = '0;
          state_d = ST_HUNT;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      default: state_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      cnt_q   <= '0;
      op_hi_q <= 1'b0;
      rd_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      op_hi_q <= op_hi_d;
      rd_q    <= rd_d;
    end
  end

  assign state_o   = state_q;
  assign is_read_o = rd_q;
endmodule

// File: rtl/mdio_tgt_datapath.sv
module mdio_tgt_datapath
  import mdio_tgt_pkg::*;
#(
  parameter int unsigned             ADDR_W   = 5,
  parameter int unsigned             DATA_W   = 16,
  parameter logic [ADDR_W-1:0]       PHY_ADDR = ADDR_W'(1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_i,
  input  fsm_t              state_i,
  input  logic              is_read_i,
  input  logic              phy_last_i,
  input  logic              reg_last_i,
  input  logic              data_last_i,
  input  logic [DATA_W-1:0] reg_rdata_i,
  input  logic              reg_valid_i,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic              reg_rd_stb_o,
  output logic              reg_wr_stb_o,
  output logic [DATA_W-1:0] reg_wdata_o
);
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              match_q, match_d;
  logic              wr_q, wr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic [ADDR_W-1:0] field_w;
  logic [DATA_W-1:0] shin_w;
  logic              commit_w;

  assign shin_w   = {sh_q[DATA_W-2:0], bit_i};
  assign field_w  = shin_w[ADDR_W-1:0];
  assign commit_w = data_last_i && !is_read_i;

  always_comb begin
    sh_d    = sh_q;
    addr_d  = addr_q;
    match_d = match_q;
    wdata_d = wdata_q;
    wr_d    = 1'b0;

    if (phy_last_i)
      match_d = (field_w == PHY_ADDR) || (field_w == '0);
    if (reg_last_i)
      addr_d = field_w;

    if ((state_i == ST_TA1) && is_read_i) begin
      sh_d = (match_q && reg_valid_i) ? reg_rdata_i : '1;
    end else if ((state_i == ST_DATA) && is_read_i) begin
      sh_d = {sh_q[DATA_W-2:0], 1'b0};
    end else if ((state_i == ST_PHY) || (state_i == ST_REG) ||
                 (state_i == ST_DATA)) begin
      sh_d = shin_w;
    end

    if (commit_w) begin
      wdata_d = shin_w;
      wr_d    = match_q && reg_valid_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      addr_q  <= '0;
      match_q <= 1'b0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
    end else begin
      sh_q    <= sh_d;
      addr_q  <= addr_d;
      match_q <= match_d;
      wr_q    <= wr_d;
      wdata_q <= wdata_d;
    end
  end

  assign mdio_oe_o    = is_read_i && match_q &&
                        ((state_i == ST_TA2) || (state_i == ST_DATA));
  assign mdio_o       = mdio_oe_o && (state_i == ST_DATA) && sh_q[DATA_W-1];
  assign reg_rd_stb_o = (state_i == ST_TA1) && is_read_i && match_q;
  assign reg_addr_o   = addr_q;
  assign reg_wr_stb_o = wr_q;
  assign reg_wdata_o  = wdata_q;
endmodule

// File: rtl/mdio_mgmt_target.sv
module mdio_mgmt_target
  import mdio_tgt_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 5,
  parameter int unsigned       DATA_W   = 16,
  parameter logic [ADDR_W-1:0] PHY_ADDR = ADDR_W'(1)
) (
  input  logic              mdc,
  input  logic              rst_n,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              reg_rd_stb,
  input  logic [DATA_W-1:0] reg_rdata,
  input  logic              reg_valid,
  output logic              reg_wr_stb,
  output logic [DATA_W-1:0] reg_wdata
);
  logic rst_n_s;
  fsm_t state_w;
  logic is_read_w, phy_last_w, reg_last_w, data_last_w;

  mdio_tgt_rst_sync #(.STAGES(2)) u_rst (
    .clk     (mdc),
    .arst_n  (rst_n),
    .rst_n_o (rst_n_s)
  );

  mdio_tgt_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk         (mdc),
    .rst_n       (rst_n_s),
    .bit_i       (mdio_i),
    .state_o     (state_w),
    .is_read_o   (is_read_w),
    .phy_last_o  (phy_last_w),
    .reg_last_o  (reg_last_w),
    .data_last_o (data_last_w)
  );

  mdio_tgt_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PHY_ADDR(PHY_ADDR)) u_dp (
    .clk          (mdc),
    .rst_n        (rst_n_s),
    .bit_i        (mdio_i),
    .state_i      (state_w),
    .is_read_i    (is_read_w),
    .phy_last_i   (phy_last_w),
    .reg_last_i   (reg_last_w),
    .data_last_i  (data_last_w),
    .reg_rdata_i  (reg_rdata),
    .reg_valid_i  (reg_valid),
    .mdio_o       (mdio_o),
    .mdio_oe_o    (mdio_oe),
    .reg_addr_o   (reg_addr),
    .reg_rd_stb_o (reg_rd_stb),
    .reg_wr_stb_o (reg_wr_stb),
    .reg_wdata_o  (reg_wdata)
  );
endmodule

// File: rtl/mdio_mgmt_target_chk.sv
module mdio_mgmt_target_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic mdc,
  input logic rst_n,
  input logic mdio_o,
  input logic mdio_oe,
  input logic reg_rd_stb,
  input logic reg_wr_stb
);
  localparam int unsigned RUN_W = $clog2(DATA_W + 2) + 1;
  localparam logic [RUN_W-1:0] RUN_LEN = RUN_W'(DATA_W + 1);

  logic [RUN_W-1:0] run_q;

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n)       run_q <= '0;
    else if (mdio_oe) run_q <= run_q + RUN_W'(1);
    else              run_q <= '0;
  end

  // R4: the target releases the line while it requests read data
  a_r4_ta_released: assert property (@(posedge mdc) disable iff (!rst_n)
    reg_rd_stb |-> !mdio_oe);

  // R4: the read strobe is followed by the driven turnaround bit
  a_r4_drive_follows: assert property (@(posedge mdc) disable iff (!rst_n)
    reg_rd_stb |=> mdio_oe);

  // R4: the first driven bit is a zero
  a_r4_first_zero: assert property (@(posedge mdc) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_o);

  // R5: the drive window lasts turnaround zero plus the data word
  a_r5_drive_len: assert property (@(posedge mdc) disable iff (!rst_n)
    $fell(mdio_oe) |-> (run_q == RUN_LEN));

  // R9: the write strobe lasts one clock
  a_r9_wr_pulse: assert property (@(posedge mdc) disable iff (!rst_n)
    reg_wr_stb |=> !reg_wr_stb);

  // R9: read and write strobes never overlap the drive window of a write
  a_r9_wr_no_drive: assert property (@(posedge mdc) disable iff (!rst_n)
    reg_wr_stb |-> (!mdio_oe && !reg_rd_stb));
endmodule

bind mdio_mgmt_target mdio_mgmt_target_chk #(.DATA_W(DATA_W)) u_chk (
  .mdc        (mdc),
  .rst_n      (rst_n),
  .mdio_o     (mdio_o),
  .mdio_oe    (mdio_oe),
  .reg_rd_stb (reg_rd_stb),
  .reg_wr_stb (reg_wr_stb)
);

// File: tb/sim_mdio_mgmt_target.sv
module sim_mdio_mgmt_target;
  localparam int AW = 5;
  localparam int DW = 16;

  logic          mdc = 1'b0;
  logic          rst_n;
  logic          mdio_i;
  logic          mdio_o, mdio_oe;
  logic [AW-1:0] reg_addr;
  logic          reg_rd_stb, reg_wr_stb;
  logic [DW-1:0] reg_rdata, reg_wdata;
  logic          reg_valid;

  logic [DW-1:0] model [32];
  logic [AW+DW-1:0] wr_q [$];
  logic [DW-1:0]    rd_q [$];

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 mdc = ~mdc;

  function automatic bit exists(input logic [AW-1:0] a);
    return (a < 8) || (a >= 16 && a <= 20);
  endfunction

  assign reg_valid = exists(reg_addr);
  assign reg_rdata = model[reg_addr];

  mdio_mgmt_target u0 (
    .mdc(mdc), .rst_n(rst_n), .mdio_i(mdio_i), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .reg_addr(reg_addr), .reg_rd_stb(reg_rd_stb),
    .reg_rdata(reg_rdata), .reg_valid(reg_valid),
    .reg_wr_stb(reg_wr_stb), .reg_wdata(reg_wdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge mdc);
      mdio_i = v[i];
      @(posedge mdc);
    end
  endtask

  task automatic header(input int pre, input logic [1:0] op,
                        input logic [AW-1:0] phy, input logic [AW-1:0] ra);
    for (int i = 0; i < pre; i++) send(1, 1);
    send(2'b01, 2);
    send(op, 2);
    send(phy, AW);
    send(ra, AW);
  endtask

  // Read: push expected word, run the frame, pop and compare the collected bits.
  task automatic do_read(input int pre, input logic [AW-1:0] phy,
                         input logic [AW-1:0] ra, input bit drive, input string tag);
    logic [DW-1:0] got, exp;
    logic oe_s, out_s, stb_s;
    rd_q.push_back((drive && exists(ra)) ? model[ra] : '1);
    header(pre, 2'b10, phy, ra);
    got = '0;
    for (int s = 0; s < DW + 3; s++) begin
      @(negedge mdc);
      oe_s = mdio_oe; out_s = mdio_o; stb_s = reg_rd_stb;
      mdio_i = 1'b1;
      if (s == 0) begin
        chk(!oe_s, {tag, " R4 ta1 released"}, oe_s, 0);
        chk(stb_s == drive, {tag, " R4 read strobe"}, stb_s, drive);
      end else if (s == 1) begin
        chk(oe_s == drive && !(drive && out_s), {tag, " R4 ta2 zero"},
            {oe_s, out_s}, {drive, 1'b0});
      end else if (s < DW + 2) begin
        if (!drive)
          chk(!oe_s, {tag, " R7 no drive"}, oe_s, 0);
        got = {got[DW-2:0], oe_s ? out_s : 1'b1};
      end else begin
        chk(!oe_s, {tag, " R5 release after data"}, oe_s, 0);
      end
      if (s != DW + 2) @(posedge mdc);
    end
    exp = rd_q.pop_front();
    chk(got == exp, {tag, " R5 read word"}, got, exp);
  endtask

  task automatic do_write(input int pre, input logic [AW-1:0] phy,
                          input logic [AW-1:0] ra, input logic [DW-1:0] d,
                          input bit commit);
    if (commit) wr_q.push_back({ra, d});
    header(pre, 2'b01, phy, ra);
    send(2'b10, 2);
    send(d, DW);
    @(negedge mdc);
    mdio_i = 1'b1;
    repeat (2) @(posedge mdc);
  endtask

  // Monitor: pops expected writes and compares what the design commits.
  initial begin
    for (int a = 0; a < 32; a++) model[a] = 16'h5A00 ^ DW'(a * 16'h0111);
    forever begin
      @(negedge mdc);
      if (reg_wr_stb) begin
        if (wr_q.size() == 0) begin
          chk(0, "R10/R7 unexpected write strobe", {11'b0, reg_addr, reg_wdata}, 0);
        end else begin
          logic [AW+DW-1:0] e;
          e = wr_q.pop_front();
          chk({reg_addr, reg_wdata} == e, "R9 committed write",
              {reg_addr, reg_wdata}, e);
          model[e[AW+DW-1:DW]] = e[DW-1:0];
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge mdc);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic seen;
    rst_n  = 1'b0;
    mdio_i = 1'b0;
    repeat (3) @(posedge mdc);
    @(negedge mdc);
    rst_n = 1'b1;
    repeat (4) @(posedge mdc);
    @(negedge mdc);
    chk(!mdio_oe && !reg_rd_stb && !reg_wr_stb, "R5 reset idle outputs",
        {mdio_oe, reg_rd_stb, reg_wr_stb}, 0);

    // R1/R2: full preamble, own address
    do_read(32, 5'd1, 5'd2, 1, "R1 R2 R6 long preamble");
    // R1: idle zeros then a single preamble one
    send(0, 3);
    do_read(1, 5'd1, 5'd3, 1, "R1 one-bit preamble");
    // R9: write then read back
    send(0, 2);
    do_write(1, 5'd1, 5'd4, 16'h1234, 1);
    do_read(4, 5'd1, 5'd4, 1, "R9 read back");
    // R6: broadcast write and read
    do_write(2, 5'd0, 5'd17, 16'hBEEF, 1);
    do_read(2, 5'd0, 5'd17, 1, "R6 broadcast");
    // R7: foreign PHY address, read and write
    do_read(2, 5'd3, 5'd6, 0, "R7 foreign read");
    do_write(2, 5'd3, 5'd6, 16'h0F0F, 0);
    do_read(2, 5'd1, 5'd6, 1, "R7 register untouched");
    // R8: missing register reads ones
    do_read(2, 5'd1, 5'd10, 1, "R8 missing register");
    // R10: write to missing register discarded
    do_write(2, 5'd1, 5'd25, 16'hAAAA, 0);
    do_read(2, 5'd1, 5'd16, 1, "R10 neighbour intact");

    // R3: bad opcodes and bad start pattern
    send(0, 2);
    send(5'b10111, 5);         // preamble, start 01, opcode 11
    send(0, 20);
    send(5'b10100, 5);         // preamble, start 01, opcode 00
    send(0, 20);
    send(3'b100, 3);           // preamble, start 00
    seen = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge mdc);
      mdio_i = 1'b0;
      if (mdio_oe || reg_rd_stb) seen = 1'b1;
      @(posedge mdc);
    end
    chk(!seen, "R3 aborted frames silent", seen, 0);
    do_read(1, 5'd1, 5'd5, 1, "R3 recovery");

    repeat (4) @(posedge mdc);
    chk(wr_q.size() == 0, "R9 all expected writes committed", wr_q.size(), 0);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule